// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a synchronous system issue single-word reads and writes to an external asynchronous static RAM whose output enable is tied permanently active. Because the memory drives its data pins whenever it is selected and not being written, the order of the strobes decides whether the shared data bus is safe. The sequencer lowers write enable first and only then activates both chip selects. It drives the bus only while the write is under way and during the hold time after it. Every timing interval is a clock-cycle count set by a parameter.

On the system side a one-cycle request carries an address, write data and a read/write flag. The request is taken only when the sequencer is idle. When the access is finished, a done pulse lasting one cycle comes back, and for a read the captured word comes with it. On the memory side the block drives the address, a low-active select, a high-active select and a low-active write enable. The data bus is split into an output value, an output-enable and an input value, and the pad ring joins them.

Top module: `sram_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, done is 0, mem_cs_n is 1, mem_cs is 0, mem_we_n is 1 and mem_dq_oe is 0.
- R2: In a write, mem_we_n falls while both selects are inactive, and the selects become active only after mem_we_n is already low. The write window is the span in which mem_cs_n=0, mem_cs=1 and mem_we_n=0.
- R3: From the cycle after a write request is accepted, the address is driven with mem_we_n low and the selects inactive for exactly T_ADDR_SETUP cycles before the window opens. mem_addr does not change while any strobe stays active.
- R4: The write window lasts max(T_PULSE, T_DATA_SETUP) cycles. Throughout it, mem_dq_oe is 1 and mem_dq_o carries the request's write data, so the word is stored at the requested address.
- R5: When the window closes, the selects go inactive first. mem_we_n stays low and the driver stays on with the same data for T_DATA_HOLD cycles, and then both are released.
- R6: After that, all strobes stay inactive for T_RECOVER cycles. done then rises with the strobes still inactive and mem_addr still equal to the request address.
- R7: mem_dq_oe is never 1 while both selects are active and mem_we_n is high.
- R8: A read keeps both selects active, mem_we_n high and mem_dq_oe low for T_READ cycles. The value on mem_dq_i in the last of those cycles appears on rdata in the cycle where done is 1, and the selects are inactive in that cycle.
- R9: Between the release of the write driver and the start of any read select there is at least one cycle with mem_dq_oe low.
- R10: done is high for exactly one cycle per accepted access. A request raised while an access is in progress is ignored: it produces no extra done and no memory write.
- R11: rdata holds its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, one cycle, taken only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last word read |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Low-active chip select |
| mem_cs | output | 1 | High-active chip select |
| mem_we_n | output | 1 | Low-active write enable |
| mem_dq_o | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | DATA_W | Data bus as seen from memory |

## Verification
Writes use all-zero, all-one and alternating data at the lowest, highest and middle addresses, so that a stuck or swapped data bit or address bit shows up on read-back through the memory model. Each write is traced cycle by cycle against the expected strobe phases, which separates an error in setup, pulse, hold or recovery length from an error in ordering. Reads are issued straight after writes to exercise the bus turnaround, and one read targets a preloaded word that was never written. Requests injected during an access of the opposite kind show whether a busy sequencer really drops them.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_W_ADDR  = 3'd1,
        ST_W_PULSE = 3'd2,
        ST_W_HOLD  = 3'd3,
        ST_W_REC   = 3'd4,
        ST_R_ACC   = 3'd5,
        ST_DONE    = 3'd6
    } seq_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned a);
        return (a < 1) ? 1 : a;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_rcap.sv
module sram_seq_rcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (en) begin
            q_d = d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q = q_q;

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 3,
    parameter int N_SETUP = 1,
    parameter int N_PULSE = 3,
    parameter int N_HOLD  = 1,
    parameter int N_REC   = 1,
    parameter int N_READ  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              cap_en,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(N_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(N_PULSE - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(N_HOLD - 1);
    localparam logic [CNT_W-1:0] LD_REC   = CNT_W'(N_REC - 1);
    localparam logic [CNT_W-1:0] LD_READ  = CNT_W'(N_READ - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              sel;
        logic              we;
        logic              oe;
        logic              done;
    } ctrl_regs_t;

    localparam ctrl_regs_t REGS_RST = '{
        state: ST_IDLE,
        addr:  '0,
        wdata: '0,
        sel:   1'b0,
        we:    1'b0,
        oe:    1'b0,
        done:  1'b0
    };

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    tmr_load  = 1'b1;
                    if (req_wr) begin
                        r_d.state = ST_W_ADDR;
                        r_d.we    = 1'b1;
                        tmr_val   = LD_SETUP;
                    end else begin
                        r_d.state = ST_R_ACC;
                        r_d.sel   = 1'b1;
                        tmr_val   = LD_READ;
                    end
                end
            end
            ST_W_ADDR: begin
                if (tmr_expired) begin
                    r_d.state = ST_W_PULSE;
                    r_d.sel   = 1'b1;
                    r_d.oe    = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_PULSE;
                end
            end
            ST_W_PULSE: begin
                if (tmr_expired) begin
                    r_d.state = ST_W_HOLD;
                    r_d.sel   = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_HOLD;
                end
            end
            ST_W_HOLD: begin
                if (tmr_expired) begin
                    r_d.state = ST_W_REC;
                    r_d.we    = 1'b0;
                    r_d.oe    = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_REC;
                end
            end
            ST_W_REC: begin
                if (tmr_expired) begin
                    r_d.state = ST_DONE;
                    r_d.done  = 1'b1;
                end
            end
            ST_R_ACC: begin
                if (tmr_expired) begin
                    cap_en    = 1'b1;
                    r_d.sel   = 1'b0;
                    r_d.state = ST_DONE;
                    r_d.done  = 1'b1;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d = REGS_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign done      = r_q.done;
    assign mem_addr  = r_q.addr;
    assign mem_cs_n  = ~r_q.sel;
    assign mem_cs    = r_q.sel;
    assign mem_we_n  = ~r_q.we;
    assign mem_dq_o  = r_q.wdata;
    assign mem_dq_oe = r_q.oe;

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int T_ADDR_SETUP = 1,
    parameter int T_PULSE      = 3,
    parameter int T_DATA_SETUP = 2,
    parameter int T_DATA_HOLD  = 1,
    parameter int T_RECOVER    = 1,
    parameter int T_READ       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int N_SETUP = at_least_one(T_ADDR_SETUP);
    localparam int N_PULSE = at_least_one(max_u(T_PULSE, T_DATA_SETUP));
    localparam int N_HOLD  = at_least_one(T_DATA_HOLD);
    localparam int N_REC   = at_least_one(T_RECOVER);
    localparam int N_READ  = at_least_one(T_READ);
    localparam int N_MAX   = max_u(max_u(N_SETUP, N_PULSE),
                                   max_u(max_u(N_HOLD, N_REC), N_READ));
    localparam int CNT_W   = (N_MAX < 2) ? 1 : $clog2(N_MAX);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cap_en;

    sram_seq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_seq_ctrl #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W),
        .N_SETUP (N_SETUP),
        .N_PULSE (N_PULSE),
        .N_HOLD  (N_HOLD),
        .N_REC   (N_REC),
        .N_READ  (N_READ)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_wr      (req_wr),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .cap_en      (cap_en),
        .done        (done),
        .mem_addr    (mem_addr),
        .mem_cs_n    (mem_cs_n),
        .mem_cs      (mem_cs),
        .mem_we_n    (mem_we_n),
        .mem_dq_o    (mem_dq_o),
        .mem_dq_oe   (mem_dq_oe)
    );

    sram_seq_rcap #(
        .DATA_W (DATA_W)
    ) u_rcap (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cap_en),
        .d     (mem_dq_i),
        .q     (rdata)
    );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    logic strobe_on;
    assign strobe_on = !mem_cs_n || mem_cs || !mem_we_n;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (mem_cs_n && !mem_cs && mem_we_n && !mem_dq_oe && !done)); // R1

    AST_WE_FALLS_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (mem_cs_n && !mem_cs)); // R2

    AST_SELECT_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_cs_n) && !mem_we_n) |-> $past(!mem_we_n)); // R2

    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on && $past(strobe_on)) |-> $stable(mem_addr)); // R3

    AST_DRIVE_ONLY_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n); // R5

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_cs_n && mem_cs && mem_we_n)); // R7

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_cs_n) && mem_we_n) |-> !$past(mem_dq_oe)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_cs_n && !mem_cs && mem_we_n && !mem_dq_oe)); // R6

endmodule

bind sram_seq sram_seq_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_cs    (mem_cs),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_seq_tb.sv
module sram_seq_tb;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int AS = 2;
    localparam int WP = 2;
    localparam int DS = 3;
    localparam int DH = 2;
    localparam int WR = 3;
    localparam int RD = 3;
    localparam int PL = (WP > DS) ? WP : DS;
    localparam int WTOT = AS + PL + DH + WR;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          req;
    logic          req_wr;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          done;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n;
    logic          mem_cs;
    logic          mem_we_n;
    logic [DW-1:0] mem_dq_o;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_dq_i;

    int n_chk  = 0;
    int n_fail = 0;
    int contention = 0;
    int since_oe = 1000;
    int min_gap  = 1000;
    bit prev_rsel = 1'b0;
    bit finished = 1'b0;

    sram_seq #(
        .ADDR_W(AW), .DATA_W(DW), .T_ADDR_SETUP(AS), .T_PULSE(WP),
        .T_DATA_SETUP(DS), .T_DATA_HOLD(DH), .T_RECOVER(WR), .T_READ(RD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    // memory model with output enable tied active
    logic [DW-1:0] mem [0:(1<<AW)-1];
    logic mem_drv, win;
    assign mem_drv = !mem_cs_n && mem_cs && mem_we_n;
    assign win     = !mem_cs_n && mem_cs && !mem_we_n;
    always_comb mem_dq_i = mem_dq_oe ? mem_dq_o : (mem_drv ? mem[mem_addr] : 'z);
    always @(negedge win) mem[mem_addr] = mem_dq_oe ? mem_dq_o : 'x;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && mem_drv) contention++;
            if (mem_drv && !prev_rsel && since_oe < min_gap) min_gap = since_oe;
            prev_rsel = mem_drv;
            since_oe  = mem_dq_oe ? 0 : since_oe + 1;
        end
    end

    task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit sel_on();
        return !mem_cs_n && mem_cs;
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit inject);
        int e_as = 0, e_pl = 0, e_dh = 0, e_wr = 0, e_addr = 0, e_dat = 0, e_done = 0;
        req = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < WTOT; k++) begin
            bit s_e, w_e, o_e, bad;
            s_e = (k >= AS) && (k < AS + PL);
            w_e = (k < AS + PL + DH);
            o_e = (k >= AS) && (k < AS + PL + DH);
            bad = (sel_on() != s_e) || (!mem_we_n != w_e) || (mem_dq_oe != o_e)
                  || (mem_cs_n == mem_cs);
            if (bad) begin
                if (k < AS) e_as++;
                else if (k < AS + PL) e_pl++;
                else if (k < AS + PL + DH) e_dh++;
                else e_wr++;
            end
            if (mem_addr != a) e_addr++;
            if (mem_dq_oe && mem_dq_o != d) e_dat++;
            if (done) e_done++;
            if (inject && k == 1) begin
                req = 1'b1; req_wr = 1'b0; req_addr = ~a;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
        end
        chk("R2/R3 write setup phase", e_as == 0, e_as, 0);
        chk("R4 write window phase", e_pl == 0, e_pl, 0);
        chk("R5 data hold phase", e_dh == 0, e_dh, 0);
        chk("R6 recovery phase", e_wr == 0, e_wr, 0);
        chk("R3 address stable", e_addr == 0, e_addr, 0);
        chk("R4 write data on bus", e_dat == 0, e_dat, 0);
        chk("R10 no early done", e_done == 0, e_done, 0);
        chk("R6 done after recovery", done && !sel_on() && mem_we_n && !mem_dq_oe, done, 1);
        chk("R6 address held at done", mem_addr == a, mem_addr, a);
        chk("R4 word stored", mem[a] === d, mem[a], d);
        @(negedge clk);
        chk("R10 done one cycle", !done, done, 0);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] x, input bit inject);
        int e_ph = 0, e_done = 0;
        logic [DW-1:0] other;
        other = mem[a ^ 1];
        req = 1'b1; req_wr = 1'b0; req_addr = a; req_wdata = ~x;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < RD; k++) begin
            if (!sel_on() || !mem_we_n || mem_dq_oe || mem_addr != a) e_ph++;
            if (done) e_done++;
            if (inject && k == 1) begin
                req = 1'b1; req_wr = 1'b1; req_addr = a ^ 1; req_wdata = ~x;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
        end
        chk("R8 read access phase", e_ph == 0, e_ph, 0);
        chk("R10 no early done", e_done == 0, e_done, 0);
        chk("R8 done with data", done && rdata == x, rdata, x);
        chk("R8 deselected at done", !sel_on(), sel_on(), 0);
        @(negedge clk);
        chk("R10 done one cycle", !done, done, 0);
        chk("R11 rdata held", rdata == x, rdata, x);
        if (inject) begin
            chk("R10 ignored write left memory", mem[a ^ 1] === other, mem[a ^ 1], other);
        end
    endtask

    task automatic idle_quiet(input int n);
        int e = 0;
        for (int k = 0; k < n; k++) begin
            if (done || sel_on() || !mem_we_n || mem_dq_oe) e++;
            @(negedge clk);
        end
        chk("R10 no spurious activity", e == 0, e, 0);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i) ^ 8'hC3;
        rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", mem_cs_n && !mem_cs && mem_we_n && !mem_dq_oe && !done,
            {mem_cs_n, mem_cs, mem_we_n, mem_dq_oe, done}, 5'b10100);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", mem_cs_n && !mem_cs && mem_we_n && !mem_dq_oe && !done,
            {mem_cs_n, mem_cs, mem_we_n, mem_dq_oe, done}, 5'b10100);
        chk("R11 rdata reset", rdata == '0, rdata, 0);

        do_read(8'h10, 8'h10 ^ 8'hC3, 1'b0);
        do_write(8'h00, 8'h00, 1'b0);
        do_write(8'hFF, 8'hFF, 1'b0);
        do_read(8'hFF, 8'hFF, 1'b0);
        do_write(8'h55, 8'hA5, 1'b1);
        do_write(8'hAA, 8'h5A, 1'b0);
        do_read(8'h00, 8'h00, 1'b0);
        do_read(8'h55, 8'hA5, 1'b1);
        do_read(8'hAA, 8'h5A, 1'b0);
        do_read(8'hAA ^ 8'h01, 8'hAB ^ 8'hC3, 1'b0);
        do_write(8'h55, 8'h0F, 1'b0);
        do_read(8'h55, 8'h0F, 1'b0);
        idle_quiet(6);

        chk("R7 no bus contention", contention == 0, contention, 0);
        chk("R9 turnaround gap", min_gap >= 1, min_gap, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule